// File: doc/BRIEF.md
# GPI Logo Control Conditioner

This block turns one general-purpose contact input into control actions for a logo inserter. The raw input passes through a synchronizer chain and a debounce filter whose hold time is set at run time. A rising-edge detector then feeds a small action stage. A two-bit mode input picks what the input does:

- hold a fixed fallback logo on air, overriding the scheduler;
- cut the logo in and out with the input level;
- step through the stored logos on each press;
- toggle the current logo on and off, as a cut or a fade.

The outputs are the logo index to show, a request to show it, a flag that asks for a fade rather than a cut, and a flag that marks an active override. The scheduler's index and enable come in as inputs. They pass through whenever the input is not asserting an override, so the block sits between the scheduler and the blending path. Outputs are combinational from the block's registers and the configuration and scheduler inputs.

Top module: `gpi_logo_ctrl`

## Requirements
- R1: A new input level reaches the action logic only after the synchronizer output has differed from the filtered level for `cfg_hold_len`+1 consecutive clocks. With two synchronizer stages, a level applied before clock edge k shows on the outputs after edge k+2+`cfg_hold_len`. Shorter pulses are dropped.
- R2: `cfg_mode` encodes 0 = override, 1 = level cut, 2 = step through logos, 3 = trigger toggle.
- R3: In mode 0 with the filtered input high, `ovr_active` is 1, `logo_en` is 1 and `logo_idx` equals `cfg_fallback_idx`, whatever the scheduler inputs are.
- R4: In mode 0 with the filtered input low, `ovr_active` is 0, `logo_idx` equals `sched_idx` and `logo_en` equals `sched_en`. This is also the state right after reset with the input low.
- R5: In mode 1, `logo_en` equals the filtered input level and `logo_idx` equals `sched_idx`.
- R6: In mode 2, `logo_en` is 1 and `logo_idx` shows a step counter. The counter resets to 0 and advances by one on each filtered rising edge, wrapping from `NUM_LOGOS`-1 to 0.
- R7: In mode 3, each filtered rising edge toggles a show state that resets to 0. `logo_en` follows that state, `logo_idx` equals `sched_idx` and `fade_req` equals `cfg_fade_sel`.
- R8: `fade_req` is 0 in modes 0 to 2, and `ovr_active` is 0 in modes 1 to 3.
- R9: A rising edge that falls in the same clock as a change of `cfg_mode` has no effect: the step counter and the toggle state keep their values. Both states keep their values while their mode is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi_raw | input | 1 | Unsynchronized contact input |
| cfg_mode | input | 2 | Function of the input (see R2) |
| cfg_hold_len | input | DEB_W | Debounce hold length in clocks, minus one |
| cfg_fallback_idx | input | IDX_W | Logo forced during override |
| cfg_fade_sel | input | 1 | Trigger mode: 1 = fade, 0 = cut |
| sched_idx | input | IDX_W | Scheduler's logo index |
| sched_en | input | 1 | Scheduler's logo enable |
| logo_idx | output | IDX_W | Logo index to show |
| logo_en | output | 1 | Logo show request |
| fade_req | output | 1 | Transition should fade rather than cut |
| ovr_active | output | 1 | Override is forcing the fallback logo |

## Verification
The bench builds the block with four logos, two synchronizer stages and a four-bit hold length. With four logos, the power-of-two wrap variant of the step counter is selected, and its wrap from 3 to 0 is reached within four presses. The narrow hold width keeps debounce windows to a few clocks. Random input toggling therefore produces both dropped glitches and accepted levels, and random mode changes now and then fall in the same cycle as a filtered edge. One directed sequence puts an edge exactly on a mode switch to show that it is suppressed.

// File: rtl/gpi_logo_pkg.sv
package gpi_logo_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      GPI_OVERRIDE   = 2'd0,
      GPI_LEVEL_CUT  = 2'd1,
      GPI_STEP       = 2'd2,
      GPI_TRIGGER    = 2'd3
   } gpi_mode_e;

endpackage

// File: rtl/gpi_sync_debounce.sv
module gpi_sync_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [DEB_W-1:0] hold_len,
   output logic             level
);

   initial begin : chk_params
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DEB_W >= 1)       else $error("DEB_W must be at least 1");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   sync_q;
   logic [DEB_W-1:0]       run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], din};
   end

   assign sync_q = chain[SYNC_STAGES-1];

   // Accept the synchronized level once it has differed for hold_len+1 clocks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level   <= 1'b0;
         run_cnt <= '0;
      end else if (sync_q == level) begin
         run_cnt <= '0;
      end else if (run_cnt >= hold_len) begin
         level   <= sync_q;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/gpi_edge_detect.sv
module gpi_edge_detect
   import gpi_logo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      level,
   input  gpi_mode_e mode,
   output logic      rise
);

   logic      level_q;
   gpi_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   // Tracks the mode every clock, reset or not, so a switch is always seen
   always_ff @(posedge clk) begin
      mode_q <= mode;
   end

   assign rise = level & ~level_q & (mode == mode_q);

endmodule

// File: rtl/gpi_logo_action.sv
module gpi_logo_action
   import gpi_logo_pkg::*;
#(
   parameter int NUM_LOGOS = 4,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             level,
   input  gpi_mode_e        mode,
   input  logic [IDX_W-1:0] fallback_idx,
   input  logic             fade_sel,
   input  logic [IDX_W-1:0] sched_idx,
   input  logic             sched_en,
   output logic [IDX_W-1:0] idx,
   output logic             en,
   output logic             fade,
   output logic             ovr
);

   initial begin : chk_params
      assert (NUM_LOGOS >= 2)          else $error("NUM_LOGOS must be at least 2");
      assert ((1 << IDX_W) >= NUM_LOGOS) else $error("IDX_W too narrow for NUM_LOGOS");
   end

   logic [IDX_W-1:0] step_idx;
   logic [IDX_W-1:0] step_next;
   logic             show_on;

   generate
      if ((1 << IDX_W) == NUM_LOGOS) begin : g_wrap_pow2
         assign step_next = step_idx + 1'b1;
      end else begin : g_wrap_cmp
         assign step_next = (step_idx == IDX_W'(NUM_LOGOS - 1)) ? '0 : step_idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_idx <= '0;
         show_on  <= 1'b0;
      end else begin
         if (rise && (mode == GPI_STEP))    step_idx <= step_next;
         if (rise && (mode == GPI_TRIGGER)) show_on  <= ~show_on;
      end
   end

   always_comb begin
      idx  = sched_idx;
      en   = sched_en;
      fade = 1'b0;
      ovr  = 1'b0;
      unique case (mode)
         GPI_OVERRIDE: begin
            if (level) begin
               idx = fallback_idx;
               en  = 1'b1;
               ovr = 1'b1;
            end
         end
         GPI_LEVEL_CUT: en = level;
         GPI_STEP: begin
            idx = step_idx;
            en  = 1'b1;
         end
         GPI_TRIGGER: begin
            en   = show_on;
            fade = fade_sel;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gpi_logo_ctrl.sv
module gpi_logo_ctrl
   import gpi_logo_pkg::*;
#(
   parameter  int NUM_LOGOS   = 4,
   parameter  int SYNC_STAGES = 2,
   parameter  int DEB_W       = 16,
   localparam int IDX_W       = (NUM_LOGOS > 1) ? $clog2(NUM_LOGOS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gpi_raw,
   input  logic [1:0]       cfg_mode,
   input  logic [DEB_W-1:0] cfg_hold_len,
   input  logic [IDX_W-1:0] cfg_fallback_idx,
   input  logic             cfg_fade_sel,
   input  logic [IDX_W-1:0] sched_idx,
   input  logic             sched_en,
   output logic [IDX_W-1:0] logo_idx,
   output logic             logo_en,
   output logic             fade_req,
   output logic             ovr_active
);

   gpi_mode_e mode;
   logic      gpi_level;
   logic      edge_rise;

   assign mode = gpi_mode_e'(cfg_mode);

   gpi_sync_debounce #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_W       (DEB_W)
   ) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (gpi_raw),
      .hold_len (cfg_hold_len),
      .level    (gpi_level)
   );

   gpi_edge_detect u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (gpi_level),
      .mode  (mode),
      .rise  (edge_rise)
   );

   gpi_logo_action #(
      .NUM_LOGOS (NUM_LOGOS),
      .IDX_W     (IDX_W)
   ) u_act (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise         (edge_rise),
      .level        (gpi_level),
      .mode         (mode),
      .fallback_idx (cfg_fallback_idx),
      .fade_sel     (cfg_fade_sel),
      .sched_idx    (sched_idx),
      .sched_en     (sched_en),
      .idx          (logo_idx),
      .en           (logo_en),
      .fade         (fade_req),
      .ovr          (ovr_active)
   );

endmodule

// File: rtl/gpi_logo_ctrl_chk.sv
module gpi_logo_ctrl_chk #(
   parameter int NUM_LOGOS = 4,
   parameter int IDX_W     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic [IDX_W-1:0] cfg_fallback_idx,
   input logic [IDX_W-1:0] logo_idx,
   input logic             logo_en,
   input logic             fade_req,
   input logic             ovr_active,
   input logic             edge_rise
);

   function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] v);
      return (v == IDX_W'(NUM_LOGOS - 1)) ? '0 : v + 1'b1;
   endfunction

   assert_override_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_active |-> (cfg_mode == 2'd0 && logo_en && logo_idx == cfg_fallback_idx));

   assert_no_fade_outside_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'd3) |-> !fade_req);

   assert_step_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2 && logo_idx != $past(logo_idx))
         |-> logo_idx == wrap_next($past(logo_idx)));

   assert_step_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd2) |-> logo_en);

   assert_toggle_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3 && $past(cfg_mode) == 2'd3 && !$past(edge_rise))
         |-> logo_en == $past(logo_en));

   assert_no_edge_on_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != $past(cfg_mode)) |-> !edge_rise);

endmodule

bind gpi_logo_ctrl gpi_logo_ctrl_chk #(
   .NUM_LOGOS (NUM_LOGOS),
   .IDX_W     (IDX_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_mode         (cfg_mode),
   .cfg_fallback_idx (cfg_fallback_idx),
   .logo_idx         (logo_idx),
   .logo_en          (logo_en),
   .fade_req         (fade_req),
   .ovr_active       (ovr_active),
   .edge_rise        (edge_rise)
);

// File: tb/tb_gpi_logo_ctrl.sv
`timescale 1ns/1ps
module tb_gpi_logo_ctrl;

   localparam int NL = 4;
   localparam int IW = 2;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gpi = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [DW-1:0] hold = '0;
   logic [IW-1:0] fb_idx = 2'd3;
   logic          fsel = 1'b0;
   logic [IW-1:0] s_idx = 2'd2;
   logic          s_en = 1'b1;
   logic [IW-1:0] idx;
   logic          en, fade, ov;

   always #5 clk = ~clk;

   gpi_logo_ctrl #(.NUM_LOGOS(NL), .SYNC_STAGES(2), .DEB_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .gpi_raw(gpi), .cfg_mode(mode),
      .cfg_hold_len(hold), .cfg_fallback_idx(fb_idx), .cfg_fade_sel(fsel),
      .sched_idx(s_idx), .sched_en(s_en), .logo_idx(idx), .logo_en(en),
      .fade_req(fade), .ovr_active(ov));

   int n_chk = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;

   // Reference model built from the requirements
   logic m_s1, m_s2, m_lvl, m_prev, m_show;
   int   m_cnt;
   logic [1:0]    m_mode_q;
   logic [IW-1:0] m_step;

   always @(posedge clk) begin
      logic r;
      r = m_lvl & ~m_prev & (mode == m_mode_q);
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prev = 0; m_cnt = 0; m_step = 0; m_show = 0;
      end else begin
         if (r && mode == 2'd2) m_step = (m_step == IW'(NL - 1)) ? '0 : m_step + 1'b1;
         if (r && mode == 2'd3) m_show = ~m_show;
         m_prev = m_lvl;
         if (m_s2 == m_lvl) m_cnt = 0;
         else if (m_cnt >= int'(hold)) begin m_lvl = m_s2; m_cnt = 0; end
         else m_cnt = m_cnt + 1;
         m_s2 = m_s1;
         m_s1 = gpi;
      end
      m_mode_q = mode;
   end

   // {idx, en, fade, ovr}
   function automatic logic [4:0] model_out();
      case (mode)
         2'd0:    return m_lvl ? {fb_idx, 1'b1, 1'b0, 1'b1} : {s_idx, s_en, 1'b0, 1'b0};
         2'd1:    return {s_idx, m_lvl, 1'b0, 1'b0};
         2'd2:    return {m_step, 1'b1, 1'b0, 1'b0};
         default: return {s_idx, m_show, fsel, 1'b0};
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         logic [4:0] e;
         string tag;
         #2;
         e = model_out();
         case (mode)
            2'd0:    tag = m_lvl ? "R2,R3" : "R2,R4";
            2'd1:    tag = "R1,R5";
            2'd2:    tag = "R6,R9";
            default: tag = "R7,R9";
         endcase
         check(tag, {5'd0, idx, en}, {5'd0, e[4:2]});
         check("R8", {6'd0, fade, ov}, {6'd0, e[1:0]});
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      gpi = 1'b1; tick(5);
      gpi = 1'b0; tick(5);
   endtask

   initial begin : watchdog
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      int first;
      void'($urandom(32'd20240611));
      tick(3);
      rst_n = 1'b1;
      chk_on = 1'b1;
      #3;
      // R4: reset state passes scheduler through
      check("R4 reset", {5'd0, idx, en}, {5'd0, 2'd2, 1'b1});
      check("R4 reset ovr", {7'd0, ov}, 8'd0);

      // R3: override forces fallback regardless of scheduler
      @(negedge clk); gpi = 1'b1; s_en = 1'b0; s_idx = 2'd1;
      tick(5); #3;
      check("R3", {4'd0, idx, en, ov}, {4'd0, 2'd3, 1'b1, 1'b1});
      @(negedge clk); gpi = 1'b0; tick(5);

      // R1: short pulse dropped, long level accepted after 3+hold edges
      mode = 2'd1; hold = 4'd3; tick(6);
      gpi = 1'b1; tick(3); gpi = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); #3;
         check("R1 glitch", {7'd0, en}, 8'd0);
      end
      @(negedge clk); gpi = 1'b1; first = 0;
      for (int n = 1; n <= 12; n++) begin
         @(negedge clk); #3;
         if (en && first == 0) first = n;
      end
      check("R1 latency", 8'(first), 8'd6);

      // R6: four presses walk 1,2,3 and wrap to 0
      @(negedge clk); mode = 2'd2; hold = '0; gpi = 1'b0; tick(6);
      for (int k = 1; k <= 4; k++) begin
         pulse(); #3;
         check("R6 wrap", {6'd0, idx}, 8'(k % 4));
      end

      // R9: edge lands on the mode switch and is ignored
      @(negedge clk); mode = 2'd1; tick(6);
      gpi = 1'b1; tick(3);
      mode = 2'd2; tick(6); #3;
      check("R9 switch", {6'd0, idx}, 8'd0);
      @(negedge clk); gpi = 1'b0; tick(5);

      // R7: trigger toggles show state with fade flag
      mode = 2'd3; fsel = 1'b1; tick(6);
      pulse(); #3;
      check("R7 on", {6'd0, en, fade}, {6'd0, 1'b1, 1'b1});
      @(negedge clk); pulse(); #3;
      check("R7 off", {6'd0, en, fade}, {6'd0, 1'b0, 1'b1});

      // Random phase
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if ($urandom_range(5) == 0) gpi = ~gpi;
         if ($urandom_range(39) == 0) mode = 2'($urandom_range(3));
         if ($urandom_range(19) == 0) fsel = 1'($urandom_range(1));
         if ($urandom_range(99) == 0) fb_idx = IW'($urandom_range(NL - 1));
         if (c % 400 == 0) hold = DW'($urandom_range(4));
         s_idx = IW'($urandom_range(NL - 1));
         s_en = 1'($urandom_range(1));
      end
      tick(2);
      chk_on = 1'b0;
      #5;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule